// File: doc/BRIEF.md
# Checkpointed Shadow Register File

This block is a register file in which every architectural register is held twice: a working copy that the datapath reads and writes, and a shadow copy that holds the state as it stood at the last checkpoint. Ordinary writes touch only the working copy. A commit strobe takes a checkpoint by copying every working register into its shadow in a single clock edge. A rollback strobe discards all work done since that checkpoint by copying every shadow register back into the working set, again in a single edge.

The block is meant for a core that runs groups of operations speculatively. The core commits when a group finishes cleanly. When a fault is seen inside a group, it rolls back, so that register state returns to the last commit point and the group can be re-run conservatively. Fault detection and re-execution are outside the block. Reads come from two combinational ports on the working copy. Writes come from one synchronous port. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `ckpt_regfile`

## Requirements
- R1: After reset, every working register and every shadow register holds zero. Reads return zero, and a rollback issued straight after reset also leaves zeros.
- R2: A write with `wr_en`=1 stores `wr_data` into working register `wr_idx` at the clock edge. Both read ports return the working value of the register they select combinationally, in the same cycle as the index changes.
- R3: A write changes only the working copy. The shadow copy keeps its value until the next commit, so a later rollback brings back the value held before the write.
- R4: A commit (`commit_i`=1, `rollback_i`=0) copies all working registers into their shadows at one clock edge.
- R5: When a write and a commit happen in the same cycle, the shadow of the written register receives the newly written value.
- R6: A rollback (`rollback_i`=1) copies all shadow registers into the working set at one clock edge.
- R7: When a write and a rollback happen in the same cycle, the write is discarded and the register takes its shadow value.
- R8: Asserting `commit_i` and `rollback_i` together is illegal. When `CHECK_EXCL`=1, an assertion reports it. In every build the design acts as a rollback only: no shadow changes and any write in that cycle is discarded.
- R9: With `wr_en`=0 and no strobe, no working or shadow register changes, whatever `wr_idx` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| wr_en | input | 1 | Write enable for the working set |
| wr_idx | input | IDXW | Register index for the write |
| wr_data | input | WIDTH | Data to write |
| commit_i | input | 1 | Checkpoint strobe: working copies go to shadows |
| rollback_i | input | 1 | Restore strobe: shadows go to working copies |
| rd_idx_a | input | IDXW | Read port A index |
| rd_data_a | output | WIDTH | Read port A data (working copy) |
| rd_idx_b | input | IDXW | Read port B index |
| rd_data_b | output | WIDTH | Read port B data (working copy) |

## Verification
The bench builds the block with `NREGS`=8, `WIDTH`=16 and `CHECK_EXCL`=0. With eight registers, a sweep can write, commit, overwrite and restore every register in a few dozen cycles, so the all-at-once nature of commit and rollback is checked on every register rather than on a sample. Turning off the exclusivity assertion lets the bench drive both strobes together and observe that rollback takes priority at the ports. The per-register assertions stay active throughout.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  // One command per cycle reaches the register pairs; rollback outranks commit.
  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_COMMIT   = 2'd1,
    CMD_ROLLBACK = 2'd2
  } ckpt_cmd_e;
endpackage

// File: rtl/ckpt_rst_sync.sv
module ckpt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ckpt_cmd_decode.sv
module ckpt_cmd_decode
  import ckpt_pkg::*;
#(
  parameter bit CHECK_EXCL = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      commit_i,
  input  logic      rollback_i,
  output ckpt_cmd_e cmd
);
  always_comb begin
    if (rollback_i)    cmd = CMD_ROLLBACK;
    else if (commit_i) cmd = CMD_COMMIT;
    else               cmd = CMD_NONE;
  end

  generate
    if (CHECK_EXCL) begin : g_excl
      // R8: both strobes in one cycle is a protocol error
      assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_i && rollback_i));
    end
  endgenerate
endmodule

// File: rtl/ckpt_reg_pair.sv
module ckpt_reg_pair
  import ckpt_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [WIDTH-1:0] wr_data,
  input  ckpt_cmd_e        cmd,
  output logic [WIDTH-1:0] work_q,
  output logic [WIDTH-1:0] shad_q
);
  logic             is_commit;
  logic             is_rollback;
  logic             work_en;
  logic             shad_en;
  logic [WIDTH-1:0] work_d;
  logic [WIDTH-1:0] shad_d;

  assign is_commit   = (cmd == CMD_COMMIT);
  assign is_rollback = (cmd == CMD_ROLLBACK);

  // next-state
  always_comb begin
    work_en = is_rollback || wr_hit;
    work_d  = is_rollback ? shad_q : wr_data;
    shad_en = is_commit;
    shad_d  = wr_hit ? wr_data : work_q;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      shad_q <= '0;
    end else begin
      if (work_en) work_q <= work_d;
      if (shad_en) shad_q <= shad_d;
    end
  end

  assert_work_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !is_rollback) |=> (work_q == $past(wr_data)));
  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_commit |=> $stable(shad_q));
  assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_commit && !wr_hit) |=> (shad_q == $past(work_q)));
  assert_commit_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_commit && wr_hit) |=> (shad_q == $past(wr_data)));
  assert_rollback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_rollback |=> (work_q == $past(shad_q)));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !is_rollback) |=> $stable(work_q));
endmodule

// File: rtl/ckpt_read_port.sv
module ckpt_read_port #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  parameter int IDXW  = 5
) (
  input  logic [WIDTH-1:0] regs [NREGS],
  input  logic [IDXW-1:0]  idx,
  output logic [WIDTH-1:0] rdata
);
  // Combinational read; indices beyond the file return zero.
  always_comb begin
    rdata = '0;
    for (int k = 0; k < NREGS; k++) begin
      if (idx == IDXW'(k)) rdata = regs[k];
    end
  end
endmodule

// File: rtl/ckpt_regfile.sv
module ckpt_regfile
  import ckpt_pkg::*;
#(
  parameter int NREGS      = 32,
  parameter int WIDTH      = 32,
  parameter bit CHECK_EXCL = 1'b1,
  localparam int IDXW      = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             commit_i,
  input  logic             rollback_i,
  input  logic [IDXW-1:0]  rd_idx_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [IDXW-1:0]  rd_idx_b,
  output logic [WIDTH-1:0] rd_data_b
);
  logic             rst_sync_n;
  ckpt_cmd_e        cmd;
  logic [NREGS-1:0] wr_hit;
  logic [WIDTH-1:0] work_set [NREGS];
  logic [WIDTH-1:0] shad_set [NREGS];

  ckpt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ckpt_cmd_decode #(.CHECK_EXCL(CHECK_EXCL)) u_dec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .commit_i   (commit_i),
    .rollback_i (rollback_i),
    .cmd        (cmd)
  );

  generate
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
      assign wr_hit[i] = wr_en && (wr_idx == IDXW'(i));

      ckpt_reg_pair #(.WIDTH(WIDTH)) u_pair (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .wr_hit  (wr_hit[i]),
        .wr_data (wr_data),
        .cmd     (cmd),
        .work_q  (work_set[i]),
        .shad_q  (shad_set[i])
      );
    end
  endgenerate

  ckpt_read_port #(.NREGS(NREGS), .WIDTH(WIDTH), .IDXW(IDXW)) u_rd_a (
    .regs  (work_set),
    .idx   (rd_idx_a),
    .rdata (rd_data_a)
  );

  ckpt_read_port #(.NREGS(NREGS), .WIDTH(WIDTH), .IDXW(IDXW)) u_rd_b (
    .regs  (work_set),
    .idx   (rd_idx_b),
    .rdata (rd_data_b)
  );

  // R7: a rollback leaves the targeted register at its shadow, not the write data
  assert_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && rollback_i) |=> (rd_idx_a != $past(wr_idx) || rd_data_a == $past(shad_set[wr_idx])));
  // R1: one cycle after the internal reset releases, the working set is still zero
  assert_reset_zero_R1: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (work_set[0] == '0 && shad_set[0] == '0));
endmodule

// File: tb/sim_ckpt_regfile.sv
module sim_ckpt_regfile;
  localparam int NREGS = 8;
  localparam int WIDTH = 16;
  localparam int IDXW  = 3;

  logic             clk;
  logic             rst_n;
  logic             wr_en;
  logic [IDXW-1:0]  wr_idx;
  logic [WIDTH-1:0] wr_data;
  logic             commit_i;
  logic             rollback_i;
  logic [IDXW-1:0]  rd_idx_a;
  logic [WIDTH-1:0] rd_data_a;
  logic [IDXW-1:0]  rd_idx_b;
  logic [WIDTH-1:0] rd_data_b;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  ckpt_regfile #(.NREGS(NREGS), .WIDTH(WIDTH), .CHECK_EXCL(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .commit_i(commit_i), .rollback_i(rollback_i),
    .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  typedef struct packed {
    logic             we;
    logic [IDXW-1:0]  wi;
    logic [WIDTH-1:0] wd;
    logic             cm;
    logic             rb;
    logic [IDXW-1:0]  ra;
    logic [WIDTH-1:0] ea;
    logic [IDXW-1:0]  rbx;
    logic [WIDTH-1:0] eb;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd1, 16'h1111, 1'b0, 1'b0, 3'd1, 16'h1111, 3'd2, 16'h0000}, // R2
    '{1'b1, 3'd2, 16'h2222, 1'b1, 1'b0, 3'd2, 16'h2222, 3'd1, 16'h1111}, // R5 write+commit
    '{1'b1, 3'd1, 16'hAAAA, 1'b0, 1'b0, 3'd1, 16'hAAAA, 3'd2, 16'h2222}, // R3
    '{1'b1, 3'd2, 16'hBBBB, 1'b0, 1'b0, 3'd2, 16'hBBBB, 3'd1, 16'hAAAA}, // R3
    '{1'b0, 3'd0, 16'h0000, 1'b0, 1'b1, 3'd1, 16'h1111, 3'd2, 16'h2222}, // R6 / R5
    '{1'b1, 3'd3, 16'h3333, 1'b0, 1'b1, 3'd3, 16'h0000, 3'd1, 16'h1111}, // R7
    '{1'b1, 3'd3, 16'h4444, 1'b0, 1'b0, 3'd3, 16'h4444, 3'd3, 16'h4444}, // R2
    '{1'b0, 3'd0, 16'h0000, 1'b1, 1'b0, 3'd3, 16'h4444, 3'd1, 16'h1111}, // R4
    '{1'b1, 3'd3, 16'h5555, 1'b0, 1'b0, 3'd3, 16'h5555, 3'd2, 16'h2222}, // R2
    '{1'b0, 3'd0, 16'h0000, 1'b0, 1'b1, 3'd3, 16'h4444, 3'd2, 16'h2222}, // R4 / R6
    '{1'b1, 3'd7, 16'hFFFF, 1'b1, 1'b1, 3'd7, 16'h0000, 3'd3, 16'h4444}, // R8
    '{1'b1, 3'd7, 16'h7777, 1'b0, 1'b0, 3'd7, 16'h7777, 3'd1, 16'h1111}, // R2
    '{1'b0, 3'd0, 16'h0000, 1'b0, 1'b1, 3'd7, 16'h0000, 3'd1, 16'h1111}, // R8: shadow untouched
    '{1'b0, 3'd0, 16'h0F0F, 1'b0, 1'b0, 3'd0, 16'h0000, 3'd3, 16'h4444}  // R9
  };
  localparam int VTAG [NV] = '{2, 5, 3, 3, 6, 7, 2, 4, 2, 6, 8, 2, 8, 9};

  task automatic check(input int tag, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    commit_i = 1'b0; rollback_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Read every register on both ports and compare with an expected value array.
  task automatic check_all(input int tag, input string what,
                           input logic [WIDTH-1:0] exp [NREGS]);
    for (int k = 0; k < NREGS; k++) begin
      rd_idx_a = IDXW'(k);
      rd_idx_b = IDXW'(NREGS - 1 - k);
      #1;
      check(tag, what, rd_data_a, exp[k]);
      check(tag, what, rd_data_b, exp[NREGS - 1 - k]);
    end
  endtask

  task automatic pulse(input logic cm, input logic rb);
    @(negedge clk);
    commit_i = cm; rollback_i = rb;
    @(negedge clk);
    commit_i = 1'b0; rollback_i = 1'b0;
  endtask

  initial begin
    logic [WIDTH-1:0] zeros [NREGS];
    logic [WIDTH-1:0] orig  [NREGS];
    for (int k = 0; k < NREGS; k++) begin
      zeros[k] = '0;
      orig[k]  = WIDTH'(16'h0101 * (k + 1) + 16'h1000);
    end
    rd_idx_a = '0; rd_idx_b = '0;
    idle_inputs();
    rst_n = 1'b0;
    do_reset();

    // R1: working set zero after reset, and rollback exposes zero shadows
    check_all(1, "reset working", zeros);
    pulse(1'b0, 1'b1);
    check_all(1, "reset shadow", zeros);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_en = VEC[v].we; wr_idx = VEC[v].wi; wr_data = VEC[v].wd;
      commit_i = VEC[v].cm; rollback_i = VEC[v].rb;
      rd_idx_a = VEC[v].ra; rd_idx_b = VEC[v].rbx;
      @(posedge clk);
      #2;
      check(VTAG[v], $sformatf("vector %0d port a", v), rd_data_a, VEC[v].ea);
      check(VTAG[v], $sformatf("vector %0d port b", v), rd_data_b, VEC[v].eb);
    end
    @(negedge clk);
    idle_inputs();

    // R2: combinational read follows index change without a clock edge
    rd_idx_a = 3'd3; #1;
    check(2, "async read idx 3", rd_data_a, 16'h4444);
    rd_idx_a = 3'd1; #1;
    check(2, "async read idx 1", rd_data_a, 16'h1111);

    // R4 / R6: full sweep over every register
    for (int k = 0; k < NREGS; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IDXW'(k); wr_data = orig[k];
    end
    @(negedge clk);
    wr_en = 1'b0;
    pulse(1'b1, 1'b0);
    for (int k = 0; k < NREGS; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IDXW'(k); wr_data = ~orig[k];
    end
    @(negedge clk);
    wr_en = 1'b0;
    pulse(1'b0, 1'b1);
    check_all(6, "sweep restore after commit", orig);

    // R9: idle cycles with junk on write bus change nothing
    @(negedge clk);
    wr_idx = 3'd5; wr_data = 16'hDEAD;
    repeat (3) @(negedge clk);
    idle_inputs();
    check_all(9, "idle hold", orig);

    // R1: reset mid-run clears both copies
    do_reset();
    check_all(1, "second reset working", zeros);
    pulse(1'b0, 1'b1);
    check_all(1, "second reset shadow", zeros);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule